// File: doc/BRIEF.md
# Dual-Rate Compressor Gain Controller

This block is the digital level controller of an input compressor stage. It watches two comparator flags taken at the amplifier output: one says the signal is above the upper threshold, the other says it is below a lower threshold set 3 dB beneath it. From these flags it steps a 7-bit gain code in 0.5 dB increments. Code 0x00 stands for -1 dB and code 0x52 for +40 dB. The analog amplifier applies the code. A requested gain, taken from a programmed 8-bit gain value, acts as the ceiling in the automatic modes and as the target in the fixed modes.

There are four modes. The two automatic modes react to the flags. In the dual-rate mode a fast counter tracks the flags, and a slow counter follows the fast one at its own pace. The applied gain is the smaller of the two, so short bursts are handled quickly and the longer-term level is handled slowly. The single-rate mode uses only the fast counter. The two fixed modes ignore the flags. One walks to the requested code one step at a time, and the other jumps to it at once. Each step rate comes from a 4-bit code. Gain may only rise after the signal has stayed below the lower threshold for a selectable hold time. A readback output returns either the programmed gain value or the live gain.

Top module: `agc_gain_ctrl`

## Requirements
- R1: Out of reset the applied gain `gain_out` is 0x46, and `gain_out` never exceeds 0x52. Code 0x00 is -1 dB, and each code step is 0.5 dB.
- R2: A requested gain `gain_reg[6:0]` above 0x52 is treated as 0x52.
- R3: With `mode` = 2'b11, `gain_out` equals the clamped requested gain one clock after the request is presented.
- R4: With `mode` = 2'b10, `gain_out` moves one code toward the clamped requested gain on each fast attack tick (going down) or fast release tick (going up), and stops when it gets there.
- R5: A rate code c gives one tick every BASE_DIV*2^(15-c) clocks. Code 15 is the fastest, and each lower code halves the rate. In `fast_rates` and `slow_rates`, bits 7:4 hold the attack code and bits 3:0 hold the release code.
- R6: In the automatic modes (`mode[1]` = 0), while `above_hi` is 1, the fast counter drops one code per fast attack tick and saturates at 0x00.
- R7: In the automatic modes, once the hold time has elapsed and `below_lo` is still 1, the fast counter rises one code per fast release tick, up to the clamped requested gain.
- R8: The hold time is HOLD_LONG clocks when `hold_sel` is 0 and HOLD_SHORT clocks when it is 1. The hold time counts consecutive clocks with `below_lo` = 1. Any clock with `below_lo` = 0 restarts it.
- R9: In the automatic modes, with both flags at 0 and the gain at or below the ceiling, the gain holds its value.
- R10: With `mode` = 2'b00, the slow counter moves one code toward the fast counter on each slow attack or slow release tick, and `gain_out` is the smaller of the two counters.
- R11: With `mode` = 2'b01, the slow counter has no effect, and `gain_out` equals the fast counter.
- R12: `readback` equals `gain_reg` when `gain_reg[7]` is 0. When `gain_reg[7]` is 1, `readback` is {1, `gain_out`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (1.28 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| above_hi | input | 1 | Amplifier output is above the upper threshold |
| below_lo | input | 1 | Amplifier output is below the lower threshold |
| gain_reg | input | 8 | Bit 7: readback select; bits 6:0: requested/ceiling gain code |
| mode | input | 2 | 00 auto dual-rate, 01 auto single-rate, 10 fixed stepped, 11 fixed immediate |
| hold_sel | input | 1 | Hold time select: 0 long, 1 short |
| fast_rates | input | 8 | Fast attack code [7:4], fast release code [3:0] |
| slow_rates | input | 8 | Slow attack code [7:4], slow release code [3:0] |
| gain_out | output | 7 | Applied gain code |
| readback | output | 8 | Programmed gain value or live gain |

## Verification
The hardest state to reach from the ports is a dual-rate condition in which the two counters have split apart. The slow counter must sit below a fast counter that has already recovered, so that the minimum rule is actually visible. The bench gets there in four moves. It presets both counters through the immediate mode, drives an attack burst, and lets the slow counter settle at the lowered value. It then releases with a short hold time, so the fast counter recovers within a few dozen clocks while the slow counter lags behind. The hold restart is reached by dropping `below_lo` for exactly one clock in the middle of a hold interval.

// File: rtl/agc_pkg.sv
// Shared encodings for the compressor gain controller.
// Assumes a 4-bit rate code per rate and four independent rates.
package agc_pkg;

    typedef enum logic [1:0] {
        AGC_AUTO_DUAL   = 2'b00,
        AGC_AUTO_SINGLE = 2'b01,
        AGC_FIXED_STEP  = 2'b10,
        AGC_FIXED_JUMP  = 2'b11
    } agc_mode_e;

    localparam int RATE_CODE_W   = 4;
    localparam int RATE_NUM      = 4;
    localparam int RATE_FAST_ATK = 0;
    localparam int RATE_FAST_REL = 1;
    localparam int RATE_SLOW_ATK = 2;
    localparam int RATE_SLOW_REL = 3;

endpackage

// File: rtl/agc_rate_tick.sv
// Rate prescaler: emits a one-clock tick every BASE_DIV * 2^(TOP-code) clocks.
// Assumes the code is quasi-static; any change of code restarts the count
// so the first period after a change is a full one.
module agc_rate_tick #(
    parameter int BASE_DIV = 8,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int TOP_CODE = (1 << CODE_W) - 1;
    localparam int CNT_W    = $clog2(BASE_DIV) + TOP_CODE + 2;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  period;
    logic [CODE_W-1:0] code_q;
    logic              changed;

    // Derive the period from the code and decide whether this clock ticks.
    always_comb begin
        period  = CNT_W'(BASE_DIV) << (CODE_W'(TOP_CODE) - code);
        changed = (code != code_q);
        tick    = !changed && (cnt_q == (period - CNT_W'(1)));
    end

    // Count clocks, wrapping on a tick and restarting on a code change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else if (changed) begin
            cnt_q  <= '0;
            code_q <= code;
        end else if (tick) begin
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/agc_hold_timer.sv
// Release hold timer: counts consecutive clocks with the low flag set and
// reports when the selected hold length has been reached.
// Assumes HOLD_SHORT <= HOLD_LONG; any clock without the flag clears the count.
module agc_hold_timer #(
    parameter int HOLD_LONG  = 64000,
    parameter int HOLD_SHORT = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_lo,
    input  logic sel_short,
    output logic done
);
    localparam int CW = $clog2(HOLD_LONG + 1);
    localparam logic [CW-1:0] LEN_LONG  = CW'(HOLD_LONG);
    localparam logic [CW-1:0] LEN_SHORT = CW'(HOLD_SHORT);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len;

    // Pick the active hold length and compare against it.
    always_comb begin
        len  = sel_short ? LEN_SHORT : LEN_LONG;
        done = (cnt_q >= len);
    end

    // Saturating count of low-flag clocks, cleared when the flag drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!below_lo) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/agc_gain_stepper.sv
// Saturating gain counter: a load wins over a step, and a decrement wins
// over an increment. Holds between 0 and GAIN_MAX.
// Assumes the load value is already within range.
module agc_gain_stepper #(
    parameter int GAIN_W   = 7,
    parameter int GAIN_MAX = 82,
    parameter int GAIN_RST = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [GAIN_W-1:0] load_val,
    input  logic              dec,
    input  logic              inc,
    output logic [GAIN_W-1:0] level
);
    localparam logic [GAIN_W-1:0] TOP  = GAIN_W'(GAIN_MAX);
    localparam logic [GAIN_W-1:0] INIT = GAIN_W'(GAIN_RST);

    // Apply load, step down or step up, with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= INIT;
        end else if (load) begin
            level <= load_val;
        end else if (dec && (level != '0)) begin
            level <= level - GAIN_W'(1);
        end else if (inc && (level < TOP)) begin
            level <= level + GAIN_W'(1);
        end
    end
endmodule

// File: rtl/agc_gain_ctrl.sv
// Compressor gain controller top. Combines four rate prescalers, a release
// hold timer, and fast and slow gain counters under a 2-bit mode.
// Assumes the comparator flags are already synchronous to clk.
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int BASE_DIV   = 8,
    parameter int HOLD_LONG  = 64000,
    parameter int HOLD_SHORT = 32000,
    parameter int GAIN_W     = 7,
    parameter int GAIN_MAX   = 82,
    parameter int GAIN_RST   = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              above_hi,
    input  logic              below_lo,
    input  logic [GAIN_W:0]   gain_reg,
    input  logic [1:0]        mode,
    input  logic              hold_sel,
    input  logic [7:0]        fast_rates,
    input  logic [7:0]        slow_rates,
    output logic [GAIN_W-1:0] gain_out,
    output logic [GAIN_W:0]   readback
);
    localparam logic [GAIN_W-1:0] TOP = GAIN_W'(GAIN_MAX);

    agc_mode_e              mode_e;
    logic [GAIN_W-1:0]      req_gain;
    logic [GAIN_W-1:0]      limit;
    logic [RATE_CODE_W-1:0] rate_code [RATE_NUM];
    logic [RATE_NUM-1:0]    tick;
    logic                   hold_done;
    logic [GAIN_W-1:0]      fast_q;
    logic [GAIN_W-1:0]      slow_q;
    logic                   f_load, f_dec, f_inc;
    logic                   s_load, s_dec, s_inc;

    // Decode the mode and clamp the requested gain to the top code.
    always_comb begin
        mode_e   = agc_mode_e'(mode);
        req_gain = gain_reg[GAIN_W-1:0];
        limit    = (req_gain > TOP) ? TOP : req_gain;
    end

    // Route each rate nibble to its prescaler.
    always_comb begin
        rate_code[RATE_FAST_ATK] = fast_rates[7:4];
        rate_code[RATE_FAST_REL] = fast_rates[3:0];
        rate_code[RATE_SLOW_ATK] = slow_rates[7:4];
        rate_code[RATE_SLOW_REL] = slow_rates[3:0];
    end

    for (genvar i = 0; i < RATE_NUM; i++) begin : g_rate
        agc_rate_tick #(
            .BASE_DIV(BASE_DIV),
            .CODE_W  (RATE_CODE_W)
        ) u_tick (
            .clk  (clk),
            .rst_n(rst_n),
            .code (rate_code[i]),
            .tick (tick[i])
        );
    end

    agc_hold_timer #(
        .HOLD_LONG (HOLD_LONG),
        .HOLD_SHORT(HOLD_SHORT)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .below_lo (below_lo),
        .sel_short(hold_sel),
        .done     (hold_done)
    );

    // Fast counter control: fixed modes chase the target, auto modes the flags.
    always_comb begin
        f_load = 1'b0;
        f_dec  = 1'b0;
        f_inc  = 1'b0;
        unique case (mode_e)
            AGC_FIXED_JUMP: f_load = 1'b1;
            AGC_FIXED_STEP: begin
                f_dec = (fast_q > limit) && tick[RATE_FAST_ATK];
                f_inc = (fast_q < limit) && tick[RATE_FAST_REL];
            end
            default: begin
                if (above_hi || (fast_q > limit)) begin
                    f_dec = tick[RATE_FAST_ATK];
                end else if (below_lo && hold_done && (fast_q < limit)) begin
                    f_inc = tick[RATE_FAST_REL];
                end
            end
        endcase
    end

    // Slow counter control: trails the fast counter in dual mode, else shadows it.
    always_comb begin
        s_load = 1'b0;
        s_dec  = 1'b0;
        s_inc  = 1'b0;
        if (mode_e == AGC_AUTO_DUAL) begin
            s_dec = (slow_q > fast_q) && tick[RATE_SLOW_ATK];
            s_inc = (slow_q < fast_q) && tick[RATE_SLOW_REL];
        end else begin
            s_load = 1'b1;
        end
    end

    agc_gain_stepper #(
        .GAIN_W  (GAIN_W),
        .GAIN_MAX(GAIN_MAX),
        .GAIN_RST(GAIN_RST)
    ) u_fast (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (f_load),
        .load_val(limit),
        .dec     (f_dec),
        .inc     (f_inc),
        .level   (fast_q)
    );

    agc_gain_stepper #(
        .GAIN_W  (GAIN_W),
        .GAIN_MAX(GAIN_MAX),
        .GAIN_RST(GAIN_RST)
    ) u_slow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (s_load),
        .load_val(fast_q),
        .dec     (s_dec),
        .inc     (s_inc),
        .level   (slow_q)
    );

    // Applied gain is the lower counter in dual mode; readback picks its source.
    always_comb begin
        gain_out = ((mode_e == AGC_AUTO_DUAL) && (slow_q < fast_q)) ? slow_q : fast_q;
        readback = gain_reg[GAIN_W] ? {1'b1, gain_out} : gain_reg;
    end
endmodule

// File: rtl/agc_gain_ctrl_chk.sv
// Property checker for agc_gain_ctrl, attached by bind. It observes ports only.
module agc_gain_ctrl_chk #(
    parameter int GAIN_W   = 7,
    parameter int GAIN_MAX = 82
) (
    input logic              clk,
    input logic              rst_n,
    input logic              above_hi,
    input logic              below_lo,
    input logic [GAIN_W:0]   gain_reg,
    input logic [1:0]        mode,
    input logic [GAIN_W-1:0] gain_out
);
    localparam logic [GAIN_W-1:0] TOP = GAIN_W'(GAIN_MAX);

    logic past_ok;

    function automatic logic [GAIN_W-1:0] clamp_gain(input logic [GAIN_W-1:0] v);
        return (v > TOP) ? TOP : v;
    endfunction

    // Mark that at least one clock has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_out <= TOP);

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (mode != 2'b11) && (mode == $past(mode)))
        |-> (({1'b0, gain_out} <= {1'b0, $past(gain_out)} + 1'b1) &&
             ({1'b0, $past(gain_out)} <= {1'b0, gain_out} + 1'b1)));

    // R3
    imm_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (mode == 2'b11) && ($past(mode) == 2'b11))
        |-> (gain_out == clamp_gain($past(gain_reg[GAIN_W-1:0]))));

    // R8
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (mode == 2'b01) && ($past(mode) == 2'b01) && !$past(below_lo))
        |-> (gain_out <= $past(gain_out)));

    // R6
    attack_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (mode == 2'b01) && ($past(mode) == 2'b01) && $past(above_hi))
        |-> (gain_out <= $past(gain_out)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (mode == 2'b01) && ($past(mode) == 2'b01) &&
         !$past(above_hi) && !$past(below_lo) &&
         ($past(gain_out) <= clamp_gain($past(gain_reg[GAIN_W-1:0]))))
        |-> (gain_out == $past(gain_out)));
endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(
    .GAIN_W  (GAIN_W),
    .GAIN_MAX(GAIN_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .above_hi(above_hi),
    .below_lo(below_lo),
    .gain_reg(gain_reg),
    .mode    (mode),
    .gain_out(gain_out)
);

// File: tb/agc_gain_ctrl_bench.sv
module agc_gain_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       above_hi = 1'b0;
    logic       below_lo = 1'b0;
    logic [7:0] gain_reg = 8'h46;
    logic [1:0] mode = 2'b00;
    logic       hold_sel = 1'b0;
    logic [7:0] fast_rates = 8'hF7;
    logic [7:0] slow_rates = 8'h42;
    logic [6:0] gain_out;
    logic [7:0] readback;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    agc_gain_ctrl #(
        .BASE_DIV  (1),
        .HOLD_LONG (40),
        .HOLD_SHORT(20)
    ) u_agc_gain_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_hi  (above_hi),
        .below_lo  (below_lo),
        .gain_reg  (gain_reg),
        .mode      (mode),
        .hold_sel  (hold_sel),
        .fast_rates(fast_rates),
        .slow_rates(slow_rates),
        .gain_out  (gain_out),
        .readback  (readback)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h..0x%0h", req, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R4, R5: fixed stepped mode over a span of ten rate periods
    task automatic rate_run(input bit attack, input int c);
        int per;
        per  = 1 << (15 - c);
        mode = 2'b11;
        gain_reg   = attack ? 8'h52 : 8'h00;
        fast_rates = attack ? {c[3:0], 4'h0} : {4'h0, c[3:0]};
        step(3);
        mode     = 2'b10;
        gain_reg = attack ? 8'h00 : 8'h52;
        step(10 * per);
        chk(attack ? "R5 attack rate" : "R5 release rate",
            gain_out, attack ? 8'h48 : 8'h0A);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R12: reset state
        chk("R1 reset gain", gain_out, 8'h46);
        chk("R12 readback reset", readback, 8'h46);

        // R2, R3, R12: immediate mode sweep over every request code
        mode = 2'b11;
        for (int v = 0; v < 128; v++) begin
            gain_reg = v[7:0];
            step(1);
            chk("R2 R3 immediate clamp", gain_out, (v > 82) ? 82 : v);
            chk("R12 readback stored", readback, v);
        end
        gain_reg = 8'hB0;
        step(1);
        chk("R12 readback live", readback, 8'hB0);
        gain_reg = 8'hE0;
        step(1);
        chk("R12 readback live clamp", readback, 8'hD2);

        // R4, R5: rate sweep in both directions
        for (int c = 15; c >= 11; c--) rate_run(1'b1, c);
        for (int c = 15; c >= 11; c--) rate_run(1'b0, c);

        // R4: stepped mode stops on the target
        mode = 2'b11; gain_reg = 8'h52; fast_rates = 8'hFF;
        step(3);
        mode = 2'b10; gain_reg = 8'h50;
        step(20);
        chk("R4 stop at target", gain_out, 8'h50);

        // R6..R9, R11: single-rate automatic
        mode = 2'b11; gain_reg = 8'h46; slow_rates = 8'h42;
        step(2);
        mode = 2'b01; gain_reg = 8'h52; hold_sel = 1'b1;
        step(2);
        chk("R9 idle", gain_out, 8'h46);
        above_hi = 1'b1;
        step(5);
        chk("R6 attack", gain_out, 8'h41);
        above_hi = 1'b0; below_lo = 1'b1;
        step(20);
        chk("R8 short hold", gain_out, 8'h41);
        step(5);
        chk("R7 R11 release after hold", gain_out, 8'h46);
        below_lo = 1'b0;
        step(1);
        below_lo = 1'b1;
        step(20);
        chk("R8 hold restart", gain_out, 8'h46);
        step(3);
        chk("R7 release resumes", gain_out, 8'h49);
        below_lo = 1'b0; hold_sel = 1'b0;
        step(1);
        below_lo = 1'b1;
        step(40);
        chk("R8 long hold", gain_out, 8'h49);
        step(3);
        chk("R7 release long", gain_out, 8'h4C);
        gain_reg = 8'h4E;
        step(100);
        chk("R7 ceiling", gain_out, 8'h4E);
        below_lo = 1'b0;
        step(50);
        chk("R9 idle hold", gain_out, 8'h4E);
        above_hi = 1'b1;
        step(200);
        chk("R6 floor", gain_out, 8'h00);
        above_hi = 1'b0;

        // R10: dual-rate
        mode = 2'b11; gain_reg = 8'h40; fast_rates = 8'hFF; slow_rates = 8'hBB;
        hold_sel = 1'b1;
        step(3);
        mode = 2'b00; gain_reg = 8'h52;
        step(2);
        chk("R10 dual idle", gain_out, 8'h40);
        above_hi = 1'b1;
        step(4);
        chk("R10 min after burst", gain_out, 8'h3C);
        above_hi = 1'b0;
        step(80);
        chk("R10 slow settled", gain_out, 8'h3C);
        below_lo = 1'b1;
        step(50);
        chk_range("R10 slow lags", gain_out, 8'h3D, 8'h3E);
        step(400);
        chk("R10 slow caught up", gain_out, 8'h52);
        below_lo = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule